// File: doc/BRIEF.md
# Fractional SPI Serial-Clock Generator

This block makes the serial clock for an SPI-style master from a fast reference clock. The rate is not set by an integer divider. A phase accumulator adds an effective step, taken from an 8-bit rate field, on every reference cycle. Each carry out of the accumulator marks the end of one serial half-period. SCK is then inverted, and a one-cycle strobe tells the shifter which edge has just happened. The resulting SCK frequency is the reference frequency times the field value divided by 512. A field of 1 gives the slowest clock (reference/512), and the largest step gives the fastest clock (reference/2).

Each of the attached devices has its own 32-bit parameter word, and the rate field sits in bits 31:24 of that word. A device-select input chooses which word and which idle-polarity bit are in force. Software programs the words, and here they are modelled only as register inputs. Chip-select timing, data shifting and FIFOs lie outside this block.

The control path is a two-state machine. In IDLE the accumulator is held at zero and SCK rests at the selected idle level. The START transition (IDLE to RUN) is taken on the first clock edge that samples the enable high. That edge loads no step. In RUN, every following edge adds the step. The STOP transition (RUN to IDLE) is taken on any edge that samples the enable low. On that same edge SCK returns to the idle level and the phase is discarded.

Top module: `sck_rate_gen`

## Requirements
- R1: While running, each clock edge adds the effective step S to an 8-bit phase. A half-period boundary (an SCK inversion) occurs exactly on the edges where the sum reaches 256, and the remainder is kept. For a power-of-two S, SCK therefore inverts every 256/S edges. Starting from a cleared phase, exactly S inversions occur in 256 accumulating edges.
- R2: The field is bits 31:24 of word `dev_sel_i` of `dev_param_i`; word d occupies bits 32d+31:32d. The other bits of the word have no effect. A select value of NUM_DEV or above uses word 0 and polarity bit 0.
- R3: A field of 255 is taken as S = 256, so SCK inverts on every running edge.
- R4: A field of 0 is taken as S = 1, the slowest rate, so SCK inverts every 256 running edges and never stalls.
- R5: An edge that samples `en_i` low leaves SCK at the selected idle level, clears both strobes and clears the phase. After reset, SCK and both strobes are 0.
- R6: `rise_o` is 1 exactly in the cycles where SCK has just gone from 0 to 1. `fall_o` is 1 exactly in the cycles where SCK has just gone from 1 to 0. They are never 1 together.
- R7: The edge that first samples `en_i` high (START) adds no step. The first SCK inversion therefore falls on edge 1 + 256/S counted from that edge (that edge being edge 1).
- R8: The idle level is bit `dev_sel_i` of `idle_pol_i` (1 means SCK idles high). The first edge of a run leaves the idle level, so with idle-high the first strobe is `fall_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds SCK idle and clears the phase |
| dev_sel_i | input | SEL_W (3) | Selected device index |
| dev_param_i | input | NUM_DEV*32 (160) | Per-device parameter words; rate field in bits 31:24 of each |
| idle_pol_i | input | NUM_DEV (5) | Per-device SCK idle level |
| sck_o | output | 1 | Serial clock |
| rise_o | output | 1 | One-cycle strobe with each SCK rising edge |
| fall_o | output | 1 | One-cycle strobe with each SCK falling edge |

## Verification
The bench goes after the two remapped field codes. A design that passed 0 through would stop the clock, and one that used 255 literally would drop one inversion in every 256 edges instead of inverting on each edge. It measures the first-edge latency after START and the phase clearing after STOP. A design that accumulated on the START edge, or kept stale phase across a stop, would produce its first edge one or more cycles early. It runs a non-power-of-two field to catch a truncating or resetting accumulator, which would show the wrong inversion count over 256 edges. It also uses idle-high polarity and an out-of-range device select to catch swapped strobes and a wrong word or field slice.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_e;

    localparam int unsigned DEV_WORD_W = 32;

endpackage

// File: rtl/sck_rate_sel.sv
module sck_rate_sel #(
    parameter int unsigned NUM_DEV  = 5,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned RATE_LSB = 24,
    parameter int unsigned RATE_W   = 8,
    parameter int unsigned SEL_W    = 3,
    localparam int unsigned STEP_W  = RATE_W + 1
) (
    input  logic [SEL_W-1:0]          dev_sel_i,
    input  logic [NUM_DEV*WORD_W-1:0] dev_param_i,
    input  logic [NUM_DEV-1:0]        idle_pol_i,
    output logic [STEP_W-1:0]         step_o,
    output logic                      idle_lvl_o
);

    localparam logic [STEP_W-1:0] FULL_STEP = STEP_W'(1) << RATE_W;
    localparam logic [RATE_W-1:0] FIELD_MAX = '1;

    logic [RATE_W-1:0] field_arr [NUM_DEV];
    logic [RATE_W-1:0] field_sel;
    logic              unused_param_bits;

    // R2: slice the rate field out of each device word
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_field
        assign field_arr[d] = dev_param_i[d*WORD_W + RATE_LSB +: RATE_W];
    end

    assign unused_param_bits = ^dev_param_i;

    // R2: out-of-range selects fall back to device 0
    always_comb begin
        field_sel  = field_arr[0];
        idle_lvl_o = idle_pol_i[0];
        for (int d = 1; d < NUM_DEV; d++) begin
            if (dev_sel_i == SEL_W'(d)) begin
                field_sel  = field_arr[d];
                idle_lvl_o = idle_pol_i[d];
            end
        end
    end

    // R3 / R4: remap the two end codes
    always_comb begin
        if (field_sel == '0) begin
            step_o = STEP_W'(1);
        end else if (field_sel == FIELD_MAX) begin
            step_o = FULL_STEP;
        end else begin
            step_o = {1'b0, field_sel};
        end
    end

endmodule

// File: rtl/sck_phase_acc.sv
module sck_phase_acc #(
    parameter int unsigned PHASE_W = 8,
    localparam int unsigned STEP_W = PHASE_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              carry_o
);

    localparam logic [STEP_W-1:0] FULL_STEP = STEP_W'(1) << PHASE_W;

    logic [PHASE_W-1:0] phase_q;
    logic [STEP_W-1:0]  sum;

    assign sum     = {1'b0, phase_q} + step_i;
    assign carry_o = run_i & sum[PHASE_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else if (clr_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= sum[PHASE_W-1:0];
        end
    end

    // R4: the decoded step is never zero and never above a full turn
    a_r4_step_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i != '0) && (step_i <= FULL_STEP));

    // R5: a clear leaves no stale phase behind
    a_r5_phase_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (phase_q == '0));

endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
    import spi_rate_pkg::*;
#(
    parameter int unsigned NUM_DEV  = 5,
    parameter int unsigned RATE_LSB = 24,
    parameter int unsigned RATE_W   = 8,
    localparam int unsigned WORD_W  = DEV_WORD_W,
    localparam int unsigned SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int unsigned STEP_W  = RATE_W + 1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      en_i,
    input  logic [SEL_W-1:0]          dev_sel_i,
    input  logic [NUM_DEV*WORD_W-1:0] dev_param_i,
    input  logic [NUM_DEV-1:0]        idle_pol_i,
    output logic                      sck_o,
    output logic                      rise_o,
    output logic                      fall_o
);

    localparam logic [STEP_W-1:0] FULL_STEP = STEP_W'(1) << RATE_W;

    gen_state_e        state_q, state_d;
    logic [STEP_W-1:0] step;
    logic              idle_lvl;
    logic              carry;
    logic              acc_clr;
    logic              acc_run;

    sck_rate_sel #(
        .NUM_DEV  (NUM_DEV),
        .WORD_W   (WORD_W),
        .RATE_LSB (RATE_LSB),
        .RATE_W   (RATE_W),
        .SEL_W    (SEL_W)
    ) u_sel (
        .dev_sel_i   (dev_sel_i),
        .dev_param_i (dev_param_i),
        .idle_pol_i  (idle_pol_i),
        .step_o      (step),
        .idle_lvl_o  (idle_lvl)
    );

    assign acc_clr = !en_i || (state_q == ST_IDLE);
    assign acc_run = en_i && (state_q == ST_RUN);

    sck_phase_acc #(
        .PHASE_W (RATE_W)
    ) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (acc_clr),
        .run_i   (acc_run),
        .step_i  (step),
        .carry_o (carry)
    );

    // Transitions: START (IDLE->RUN), STOP (RUN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_i)  state_d = ST_RUN;
            ST_RUN:  if (!en_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sck_o  <= 1'b0;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sck_o  <= idle_lvl;
                    rise_o <= 1'b0;
                    fall_o <= 1'b0;
                end
                ST_RUN: begin
                    if (!en_i) begin
                        sck_o  <= idle_lvl;
                        rise_o <= 1'b0;
                        fall_o <= 1'b0;
                    end else if (carry) begin
                        sck_o  <= ~sck_o;
                        rise_o <= ~sck_o;
                        fall_o <= sck_o;
                    end else begin
                        rise_o <= 1'b0;
                        fall_o <= 1'b0;
                    end
                end
                default: begin
                    sck_o  <= idle_lvl;
                    rise_o <= 1'b0;
                    fall_o <= 1'b0;
                end
            endcase
        end
    end

    // R6: strobes are exclusive and match the SCK edge just made
    a_r6_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o && fall_o));

    a_r6_rise_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && rise_o) |-> (sck_o && !$past(sck_o)));

    a_r6_fall_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && fall_o) |-> (!sck_o && $past(sck_o)));

    // R5: a low enable parks SCK at the idle level with no strobe
    a_r5_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(en_i)) |-> ((sck_o == $past(idle_lvl)) && !rise_o && !fall_o));

    // R3: a full step inverts SCK on every running edge
    a_r3_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(en_i) && $past(state_q == ST_RUN) && ($past(step) == FULL_STEP))
        |-> (sck_o != $past(sck_o)));

endmodule

// File: tb/sck_rate_gen_tb.sv
module sck_rate_gen_tb_top;

    localparam int NUM_DEV = 5;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  en = 1'b0;
    logic [2:0]            dev_sel = '0;
    logic [NUM_DEV*32-1:0] dev_param = '0;
    logic [NUM_DEV-1:0]    idle_pol = '0;
    logic                  sck, rise, fall;

    int checks = 0;
    int errors = 0;
    int tgl_cnt = 0;

    always #10 clk = ~clk;

    sck_rate_gen dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .en_i        (en),
        .dev_sel_i   (dev_sel),
        .dev_param_i (dev_param),
        .idle_pol_i  (idle_pol),
        .sck_o       (sck),
        .rise_o      (rise),
        .fall_o      (fall)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Behavioural reference model
    bit m_valid = 0, m_run = 0, m_sck = 0, m_rise = 0, m_fall = 0;
    int m_phase = 0;

    function automatic int model_step(input int f);
        if (f == 0) return 1;
        if (f == 255) return 256;
        return f;
    endfunction

    always @(posedge clk) begin
        int sel, s;
        bit lvl;
        if (!rst_n) begin
            m_valid = 0; m_run = 0; m_phase = 0;
            m_sck = 0; m_rise = 0; m_fall = 0;
        end else begin
            sel = (int'(dev_sel) < NUM_DEV) ? int'(dev_sel) : 0;
            s   = model_step(int'(dev_param[sel*32+24 +: 8]));
            lvl = idle_pol[sel];
            m_valid = 1;
            if (!en) begin
                m_run = 0; m_phase = 0; m_sck = lvl; m_rise = 0; m_fall = 0;
            end else if (!m_run) begin
                m_run = 1; m_phase = 0; m_sck = lvl; m_rise = 0; m_fall = 0;
            end else begin
                m_phase += s;
                m_rise = 0; m_fall = 0;
                if (m_phase >= 256) begin
                    m_phase -= 256;
                    m_rise = !m_sck;
                    m_fall = m_sck;
                    m_sck  = !m_sck;
                end
            end
        end
    end

    // R6 (and R1): compare with the model every cycle
    always @(negedge clk) begin
        if (rst_n && m_valid) begin
            chk("R6 sck vs model", int'(sck), int'(m_sck));
            chk("R6 rise vs model", int'(rise), int'(m_rise));
            chk("R6 fall vs model", int'(fall), int'(m_fall));
        end
    end

    always @(sck) if (rst_n) tgl_cnt++;

    task automatic set_dev(input int d, input int field, input bit pol);
        dev_param[d*32 +: 32] = {field[7:0], 24'hA5_3C_E1};
        idle_pol[d] = pol;
    endtask

    task automatic park();
        en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic measure(output int first, output int half, output bit first_fall);
        logic lvl;
        int n;
        int m;
        lvl = sck;
        en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (sck == lvl && n < 700);
        first = n;
        first_fall = fall;
        lvl = sck;
        m = 0;
        do begin @(negedge clk); m++; end while (sck == lvl && m < 700);
        half = m;
    endtask

    task automatic rate_case(input string req, input int field, input int half_exp);
        int f, h;
        bit ff;
        set_dev(0, field, 1'b0);
        dev_sel = 3'd0;
        park();
        measure(f, h, ff);
        chk({req, " R7 first edge"}, f, 1 + half_exp);
        chk({req, " half period"}, h, half_exp);
        park();
    endtask

    task automatic count_case(input int field, input int exp);
        set_dev(0, field, 1'b0);
        dev_sel = 3'd0;
        park();
        en = 1'b1;
        @(negedge clk);
        tgl_cnt = 0;
        repeat (256) @(negedge clk);
        chk("R1 inversions in 256 edges", tgl_cnt, exp);
        park();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int f, h;
        bit ff;
        set_dev(0, 128, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset sck", int'(sck), 0);
        chk("R5 reset rise", int'(rise), 0);
        chk("R5 reset fall", int'(fall), 0);

        // R8: idle-high level while disabled
        idle_pol[0] = 1'b1;
        park();
        chk("R8 idle high level", int'(sck), 1);
        idle_pol[0] = 1'b0;
        park();
        chk("R8 idle low level", int'(sck), 0);

        // R1 powers of two, R3, R4
        rate_case("R1 field128", 128, 2);
        rate_case("R1 field64", 64, 4);
        rate_case("R1 field8", 8, 32);
        rate_case("R1 field1", 1, 256);
        rate_case("R3 field255", 255, 1);
        rate_case("R4 field0", 0, 256);

        // R8: idle-high, first strobe is a fall
        set_dev(0, 64, 1'b1);
        park();
        measure(f, h, ff);
        chk("R8 first strobe is fall", int'(ff), 1);
        chk("R8 half period idle-high", h, 4);
        park();

        // R2: device select, junk bits ignored, out-of-range -> word 0
        set_dev(0, 128, 1'b0);
        set_dev(2, 32, 1'b0);
        dev_sel = 3'd2;
        park();
        measure(f, h, ff);
        chk("R2 device 2 half period", h, 8);
        park();
        dev_sel = 3'd6;
        park();
        measure(f, h, ff);
        chk("R2 out-of-range select", h, 2);
        park();

        // R5: stop with SCK away from idle, then restart from cleared phase
        set_dev(0, 16, 1'b0);
        dev_sel = 3'd0;
        park();
        en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R5 sck away from idle before stop", int'(sck), 1);
        en = 1'b0;
        @(negedge clk);
        chk("R5 sck back to idle", int'(sck), 0);
        chk("R5 no rise after stop", int'(rise), 0);
        chk("R5 no fall after stop", int'(fall), 0);
        measure(f, h, ff);
        chk("R5 restart first edge", f, 17);
        park();

        // R1: fractional steps
        count_case(3, 3);
        count_case(100, 100);
        count_case(255, 256);

        finish_run();
    end

endmodule